// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block takes the destination part of an interrupt routing entry and turns it into injections. The entry gives a destination ID, a mode bit that picks physical or logical addressing, a delivery mode and a vector. A flat table of up to sixteen processors describes each target: a present flag, a physical ID, an 8-bit logical ID and a 4-bit priority. The block first resolves the destination into a mask of processors. It then sends injection pulses that carry the processor index, the vector and the trigger mode.

Fixed delivery sends one pulse per selected processor, one per cycle, starting from the lowest index. Lowest-priority delivery sends a single pulse to the processor with the smallest priority value. Every other delivery code is refused: the block sends nothing and reports the code as unsupported. A request is taken only while the block is idle. The processor table is sampled in the accepting cycle. Each request closes with a one-cycle done pulse.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical addressing (mode bit 0), destination 0xFF selects every processor whose present flag is set.
- R2: In physical addressing with any other destination, only the lowest-index present processor whose physical ID equals the destination is selected. Other processors with the same ID are not selected.
- R3: In logical addressing (mode bit 1), destination 0 selects nobody. Any other destination selects every present processor whose logical ID ANDed with the destination is non-zero.
- R4: When the resolved set is empty, no injection occurs. Done rises in the cycle after acceptance.
- R5: Delivery code 0 (fixed) gives one injection pulse per selected processor on consecutive cycles, in ascending index order. The first pulse comes in the cycle after acceptance. Each pulse carries the request's vector and trigger bit.
- R6: Delivery code 1 (lowest priority) gives exactly one injection. It goes to the selected processor with the smallest 4-bit priority value, and ties go to the lowest index.
- R7: Delivery codes 2 to 7 give no injection. Unsupported is asserted together with done, in the cycle after acceptance.
- R8: Done is a single-cycle pulse in the cycle after the last injection. The ready output is high only when idle. A request presented while not ready is ignored.
- R9: After reset the block is ready, and inj_valid, done and unsupported are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High when idle and able to accept |
| req_dest | input | 8 | Destination ID |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_dmode | input | 3 | Delivery code: 0 fixed, 1 lowest priority, others unsupported |
| req_vector | input | 8 | Vector to inject |
| req_level | input | 1 | Trigger mode bit to inject |
| cpu_present | input | 16 | Present flag per processor |
| cpu_phys_id | input | 128 | Physical ID per processor, 8 bits each, processor i at bits 8i+7:8i |
| cpu_log_id | input | 128 | Logical ID per processor, 8 bits each, processor i at bits 8i+7:8i |
| cpu_prio | input | 64 | Priority per processor, 4 bits each, processor i at bits 4i+3:4i |
| inj_valid | output | 1 | Injection pulse |
| inj_cpu | output | 4 | Target processor index |
| inj_vector | output | 8 | Injected vector |
| inj_level | output | 1 | Injected trigger mode |
| done | output | 1 | Request finished |
| unsupported | output | 1 | Request refused for its delivery code (with done) |

## Verification
The bench builds a processor table on purpose to expose the tricky cases. Two processors share a physical ID, and an absent processor holds the same ID as a later present one; a design that keeps the last match, or that ignores the present flag, would inject into the wrong index. Logical destination zero and unmatched physical IDs must yield done with no pulse; a design that treats zero as a match-all would flood every processor. Lowest-priority cases include priority ties and absent candidates, which catch a design that keeps the highest index or considers missing processors. Each injection is checked for vector, trigger bit and strictly rising index. A request held during a busy period must leave the pulse train unchanged.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_DONE} rs_state_t;
  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;
endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
  parameter int N_CPU = 16,
  parameter int ID_W  = 8
) (
  input  logic [ID_W-1:0]       dest,
  input  logic                  logical,
  input  logic [N_CPU-1:0]      present,
  input  logic [N_CPU*ID_W-1:0] phys_id,
  input  logic [N_CPU*ID_W-1:0] log_id,
  output logic [N_CPU-1:0]      mask
);
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  logic [N_CPU-1:0] phys_hit;
  logic [N_CPU-1:0] log_hit;
  logic [N_CPU-1:0] phys_first;

  for (genvar i = 0; i < N_CPU; i++) begin : g_cmp
    assign phys_hit[i] = present[i] && (phys_id[i*ID_W +: ID_W] == dest);
    assign log_hit[i]  = present[i] && (|(log_id[i*ID_W +: ID_W] & dest));
  end

  // isolate the lowest set bit of the physical hits
  assign phys_first = phys_hit & (~phys_hit + N_CPU'(1));

  always_comb begin
    if (logical) begin
      mask = (dest == '0) ? '0 : log_hit;
    end else begin
      mask = (dest == BCAST) ? present : phys_first;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_CPU  = 16,
  parameter int PRIO_W = 4
) (
  input  logic [N_CPU-1:0]        cand,
  input  logic [N_CPU*PRIO_W-1:0] prio,
  output logic [N_CPU-1:0]        onehot
);
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  logic              found;
  logic [IDX_W-1:0]  best;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    found  = 1'b0;
    best   = '0;
    best_p = '1;
    for (int i = 0; i < N_CPU; i++) begin
      if (cand[i] && (!found || (prio[i*PRIO_W +: PRIO_W] < best_p))) begin
        found  = 1'b1;
        best   = IDX_W'(i);
        best_p = prio[i*PRIO_W +: PRIO_W];
      end
    end
    onehot = '0;
    if (found) onehot[best] = 1'b1;
  end
endmodule

// File: rtl/irq_low_index.sv
module irq_low_index #(
  parameter int N_CPU = 16,
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic [N_CPU-1:0] vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_CPU - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int N_CPU  = 16,
  parameter int ID_W   = 8,
  parameter int VEC_W  = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ID_W-1:0]         req_dest,
  input  logic                    req_logical,
  input  logic [2:0]              req_dmode,
  input  logic [VEC_W-1:0]        req_vector,
  input  logic                    req_level,
  input  logic [N_CPU-1:0]        cpu_present,
  input  logic [N_CPU*ID_W-1:0]   cpu_phys_id,
  input  logic [N_CPU*ID_W-1:0]   cpu_log_id,
  input  logic [N_CPU*PRIO_W-1:0] cpu_prio,
  output logic                    inj_valid,
  output logic [IDX_W-1:0]        inj_cpu,
  output logic [VEC_W-1:0]        inj_vector,
  output logic                    inj_level,
  output logic                    done,
  output logic                    unsupported
);
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  rs_state_t         state_q, state_d;
  logic [N_CPU-1:0]  mask_q, mask_d;
  logic [VEC_W-1:0]  vec_q;
  logic              lvl_q;
  logic              unsup_q, unsup_d;
  logic              lowest_q, lowest_d;
  logic              accept;
  logic [N_CPU-1:0]  match_mask;
  logic [N_CPU-1:0]  pick_mask;
  logic [IDX_W-1:0]  cur_idx;

  irq_dest_match #(.N_CPU(N_CPU), .ID_W(ID_W)) i_match (
    .dest(req_dest), .logical(req_logical), .present(cpu_present),
    .phys_id(cpu_phys_id), .log_id(cpu_log_id), .mask(match_mask)
  );

  irq_prio_pick #(.N_CPU(N_CPU), .PRIO_W(PRIO_W)) i_pick (
    .cand(match_mask), .prio(cpu_prio), .onehot(pick_mask)
  );

  irq_low_index #(.N_CPU(N_CPU)) i_low (
    .vec(mask_q), .idx(cur_idx)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // next state
  always_comb begin
    state_d  = state_q;
    mask_d   = mask_q;
    unsup_d  = unsup_q;
    lowest_d = lowest_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unsup_d  = 1'b0;
          lowest_d = 1'b0;
          if (req_dmode == DM_FIXED) begin
            mask_d = match_mask;
          end else if (req_dmode == DM_LOWEST) begin
            mask_d   = pick_mask;
            lowest_d = 1'b1;
          end else begin
            mask_d  = '0;
            unsup_d = 1'b1;
          end
          state_d = (mask_d != '0) ? ST_SEND : ST_DONE;
        end
      end
      ST_SEND: begin
        mask_d = mask_q;
        mask_d[cur_idx] = 1'b0;
        if (mask_d == '0) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        unsup_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      unsup_q  <= 1'b0;
      lowest_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      mask_q   <= mask_d;
      unsup_q  <= unsup_d;
      lowest_q <= lowest_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      lvl_q <= 1'b0;
    end else if (accept) begin
      vec_q <= req_vector;
      lvl_q <= req_level;
    end
  end

  assign inj_valid   = (state_q == ST_SEND);
  assign inj_cpu     = cur_idx;
  assign inj_vector  = vec_q;
  assign inj_level   = lvl_q;
  assign done        = (state_q == ST_DONE);
  assign unsupported = done && unsup_q;

  // R2: a physical non-broadcast destination resolves to at most one target
  p_phys_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_logical && (req_dest != BCAST)) |-> $onehot0(match_mask));

  // R3: logical destination zero resolves to nobody
  p_log_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_logical && (req_dest == '0)) |-> (match_mask == '0));

  // R5: consecutive pulses go to strictly rising indices
  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && $past(inj_valid)) |-> (inj_cpu > $past(inj_cpu)));

  // R5: vector and trigger stay fixed across one pulse train
  p_payload_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && $past(inj_valid)) |-> ($stable(inj_vector) && $stable(inj_level)));

  // R6: lowest-priority delivery holds exactly one target
  p_lowest_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && lowest_q) |-> $onehot(mask_q));

  // R6: lowest-priority delivery gives a single pulse
  p_lowest_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && lowest_q) |=> !inj_valid);

  // R7: refused codes never inject
  p_unsup_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (done && !inj_valid));

  // R8: done lasts one cycle and is followed by idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R8: no pulse while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!inj_valid && !done));
endmodule

// File: tb/test_irq_dest_resolver.sv
module test_irq_dest_resolver;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [7:0]    req_dest;
  logic          req_logical;
  logic [2:0]    req_dmode;
  logic [7:0]    req_vector;
  logic          req_level;
  logic [N-1:0]  cpu_present;
  logic [N*8-1:0] cpu_phys_id;
  logic [N*8-1:0] cpu_log_id;
  logic [N*4-1:0] cpu_prio;
  logic          inj_valid;
  logic [3:0]    inj_cpu;
  logic [7:0]    inj_vector;
  logic          inj_level;
  logic          done;
  logic          unsupported;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_dest_resolver i_irq_dest_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_dmode(req_dmode),
    .req_vector(req_vector), .req_level(req_level), .cpu_present(cpu_present),
    .cpu_phys_id(cpu_phys_id), .cpu_log_id(cpu_log_id), .cpu_prio(cpu_prio),
    .inj_valid(inj_valid), .inj_cpu(inj_cpu), .inj_vector(inj_vector),
    .inj_level(inj_level), .done(done), .unsupported(unsupported)
  );

  // fields: dest(8) logical(4) dmode(4) vector(8) level(4) exp_mask(16) exp_unsup(4)
  localparam int NV = 18;
  localparam logic [47:0] VECS [NV] = '{
    48'hFF_0_0_21_0_EFDF_0,  // R1 broadcast, cpus 5 and 12 absent
    48'h13_0_0_22_1_0008_0,  // R2 unique id
    48'h40_0_0_23_0_0080_0,  // R2 duplicate id, lowest index wins
    48'h30_0_0_24_1_2000_0,  // R2 absent holder skipped
    48'h99_0_0_25_0_0000_0,  // R4 no physical match
    48'h00_1_0_26_0_0000_0,  // R3 logical zero
    48'h09_1_0_27_1_0909_0,  // R3 logical multi
    48'h20_1_0_28_0_2000_0,  // R3 absent excluded
    48'h09_1_1_29_1_0008_0,  // R6 tie goes to lower index
    48'h41_1_1_2A_0_0040_0,  // R6 unique minimum
    48'hFF_0_1_2B_0_0008_0,  // R6 broadcast candidates
    48'h10_1_1_2C_1_0010_0,  // R6 absent candidate ignored
    48'h00_1_1_2D_0_0000_0,  // R4 lowest with empty set
    48'hFF_0_2_2E_0_0000_1,  // R7
    48'hFF_0_4_2F_0_0000_1,  // R7
    48'h13_0_5_30_0_0000_1,  // R7
    48'hFF_0_7_31_0_0000_1,  // R7
    48'h99_0_1_32_0_0000_0   // R4 lowest, no match
  };

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // presents a request for one cycle and collects the resulting pulses
  task automatic run_req(input logic [7:0] d, input logic lg, input logic [2:0] dm,
                         input logic [7:0] v, input logic lv, input logic hold_busy,
                         output logic [N-1:0] got, output logic got_unsup,
                         output logic order_ok, output logic pay_ok, output logic first_ok,
                         input logic [N-1:0] exp);
    int prev = -1;
    int n = 0;
    got = '0; got_unsup = 1'b0; order_ok = 1'b1; pay_ok = 1'b1; first_ok = 1'b1;
    @(negedge clk);
    req_dest = d; req_logical = lg; req_dmode = dm; req_vector = v;
    req_level = lv; req_valid = 1'b1;
    @(negedge clk);
    if (hold_busy) begin
      req_dest = 8'h13; req_logical = 1'b0; req_dmode = 3'd0;
      req_vector = 8'h77; req_level = ~lv;
    end else begin
      req_valid = 1'b0;
    end
    // first sample, one cycle after acceptance
    if (exp != '0) first_ok = inj_valid;
    else           first_ok = done && !inj_valid;
    while (n < 40) begin
      if (inj_valid) begin
        if (int'(inj_cpu) <= prev) order_ok = 1'b0;
        prev = int'(inj_cpu);
        got[inj_cpu] = 1'b1;
        if (inj_vector != v || inj_level != lv) pay_ok = 1'b0;
      end
      if (done) begin
        got_unsup = unsupported;
        req_valid = 1'b0;
        break;
      end
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] got;
    logic gu, ok_ord, ok_pay, ok_first;
    rst_n = 1'b0;
    req_valid = 1'b0; req_dest = '0; req_logical = 1'b0; req_dmode = '0;
    req_vector = '0; req_level = 1'b0;
    cpu_present = 16'hEFDF;
    for (int i = 0; i < N; i++) begin
      cpu_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
      cpu_log_id[i*8 +: 8]  = 8'(1 << (i % 8));
      cpu_prio[i*4 +: 4]    = 4'd8;
    end
    cpu_phys_id[5*8 +: 8]  = 8'h30;
    cpu_phys_id[13*8 +: 8] = 8'h30;
    cpu_phys_id[7*8 +: 8]  = 8'h40;
    cpu_phys_id[10*8 +: 8] = 8'h40;
    cpu_prio[3*4 +: 4]  = 4'd2;
    cpu_prio[11*4 +: 4] = 4'd2;
    cpu_prio[6*4 +: 4]  = 4'd5;
    cpu_prio[12*4 +: 4] = 4'd0;  // absent, must be ignored
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9", "ready", int'(req_ready), 1);
    check(!inj_valid && !done && !unsupported, "R9", "quiet outputs",
          int'({inj_valid, done, unsupported}), 0);

    for (int k = 0; k < NV; k++) begin
      logic [47:0] e;
      e = VECS[k];
      run_req(e[47:40], e[36], e[34:32], e[31:24], e[20], 1'b0,
              got, gu, ok_ord, ok_pay, ok_first, e[19:4]);
      check(got == e[19:4], "R1/R2/R3/R6 target set", $sformatf("row %0d", k),
            int'(got), int'(e[19:4]));
      check(gu == e[0], "R7 unsupported flag", $sformatf("row %0d", k), int'(gu), int'(e[0]));
      check(ok_first, "R4/R5 first-cycle timing", $sformatf("row %0d", k), int'(ok_first), 1);
      check(ok_ord, "R5 ascending order", $sformatf("row %0d", k), int'(ok_ord), 1);
      check(ok_pay, "R5 vector/trigger", $sformatf("row %0d", k), int'(ok_pay), 1);
    end

    // R8: request held during a busy train is ignored
    run_req(8'hFF, 1'b0, 3'd0, 8'h5A, 1'b1, 1'b1, got, gu, ok_ord, ok_pay, ok_first, 16'hEFDF);
    check(got == 16'hEFDF, "R8", "busy hold set", int'(got), 16'hEFDF);
    check(ok_pay, "R8", "busy hold payload", int'(ok_pay), 1);
    check(req_ready && !done, "R8", "idle after done", int'({req_ready, done}), 2);

    // R8: done is one cycle; R9 reset mid-train
    @(negedge clk);
    req_dest = 8'hFF; req_logical = 1'b0; req_dmode = 3'd0; req_vector = 8'h11;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8", "not ready while sending", int'(req_ready), 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !inj_valid && !done, "R9", "reset mid-train",
          int'({req_ready, inj_valid, done}), 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule